// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Queue

This block sits beside the inbound write path of a PCIe root port on the host side. It watches every inbound memory write and keeps those that land inside a programmable address window. Each kept write is queued as a record holding its 32-bit payload and its full 64-bit target address. Software programs the window and drains the queue through a simple 32-bit register port. A level interrupt line stays high for as long as any record is waiting.

A record leaves the queue only after software has read all three of its fields. The payload and the low address word may be read in either order. The read of the high address word then retires the record. This read-progress tracking is a four-state machine. PR_NONE means nothing has been read. PR_DATA means the payload has been read. PR_LO means the low address word has been read. PR_BOTH means both have been read. The named transitions are:
- data-read takes PR_NONE to PR_DATA.
- lo-read takes PR_NONE to PR_LO.
- lo-read takes PR_DATA to PR_BOTH.
- data-read takes PR_LO to PR_BOTH.
- hi-read-retire takes PR_BOTH back to PR_NONE and pops the head record.

Any other read leaves the state as it is. While the queue is empty, no read moves the state.

For a 16-vector setup, vector n is raised by a write of value n to window base plus 4·n. Software normally programs a window size of 4096 bytes.

Top module: `msi_trap`

## Requirements
- R1: After reset, the base words, the size, the enable bit, the queue and status bits 1:0 are all zero, and `irq_o` is low.
- R2: The register offsets are as follows:
  - 0x04 is base bits 31:0 and 0x08 is base bits 63:32. Both are read/write.
  - 0x0C is the window size in bytes, read/write.
  - 0x14 is the enable register. Only bit 0 is stored, and the other bits read as 0.
  - 0x18 is status. Bit 0 means pending and bit 1 means overflow.
  - 0x20 is the head payload, 0x24 is head address bits 31:0 and 0x28 is head address bits 63:32.
- R3: An inbound write is queued only when enable bit 0 is 1 and base ≤ address < base + size. The compare uses a 65-bit sum, so it does not wrap. Any other inbound write leaves the queue and the status unchanged.
- R4: Records are read out in arrival order. Each record returns the exact 32-bit payload and 64-bit address of its write. For example, vector n written as value n to base+4n reads back as data n and address base+4n.
- R5: Status bit 0 and `irq_o` are both 1 exactly while the queue holds at least one record.
- R6: The head record is popped on a read of 0x28 only if 0x20 and 0x24 of that record have both been read before it, in either order. Reading 0x20 or 0x24 alone, or reading 0x28 too early, pops nothing. A pop clears the read progress.
- R7: While the queue is empty, reads of 0x20, 0x24 and 0x28 return 0 and change nothing.
- R8: The queue holds 16 records. A write that would be queued while 16 records are held is dropped. This holds even if a pop happens in the same cycle. The drop sets status bit 1.
- R9: Status bit 1 stays set until software writes 0x18 with bit 1 = 1. A write with bit 1 = 0 leaves it set.
- R10: A queued write and a pop in the same cycle both take effect, so the number of held records does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr_valid | input | 1 | Inbound memory write present this cycle |
| in_wr_addr | input | 64 | Inbound write target address |
| in_wr_data | input | 32 | Inbound write payload |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Level interrupt, high while records are pending |

## Verification
Some behaviours are checked by assertions on every cycle:
- The occupancy count never exceeds the depth.
- A capture and a pop in the same cycle leave the count unchanged.
- A payload-only read never retires a record.
- Empty-queue reads return zero.
- The overflow flag stays set until it is cleared.
- The interrupt falls once the last record is retired.

Some behaviours only the bench scenarios can show:
- Arrival order and exact field contents.
- The window edges at base−4 and base+size.
- Out-of-order payload and low-address reads.
- The drop that happens when the queue is full with a pop in the same cycle.
- Long random mixes of captures and partial reads.

// File: rtl/msi_trap_pkg.sv
package msi_trap_pkg;
    localparam int MSG_DATA_W = 32;
    localparam int MSG_ADDR_W = 64;

    localparam logic [7:0] OFS_BASE_LO  = 8'h04;
    localparam logic [7:0] OFS_BASE_HI  = 8'h08;
    localparam logic [7:0] OFS_SIZE     = 8'h0C;
    localparam logic [7:0] OFS_ENABLE   = 8'h14;
    localparam logic [7:0] OFS_STATUS   = 8'h18;
    localparam logic [7:0] OFS_POP_DATA = 8'h20;
    localparam logic [7:0] OFS_POP_ADLO = 8'h24;
    localparam logic [7:0] OFS_POP_ADHI = 8'h28;

    typedef enum logic [1:0] {
        PR_NONE,
        PR_DATA,
        PR_LO,
        PR_BOTH
    } progress_e;

    typedef struct packed {
        logic [MSG_ADDR_W-1:0] addr;
        logic [MSG_DATA_W-1:0] data;
    } msi_entry_t;
endpackage

// File: rtl/msi_trap_window.sv
module msi_trap_window #(
    parameter int AW = 64,
    parameter int SW = 32
) (
    input  logic          enable,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] size,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    output logic          hit
);
    localparam int PAD_W = AW + 1 - SW;

    logic [AW:0] limit;

    always_comb begin
        limit = {1'b0, base} + {{PAD_W{1'b0}}, size};
        hit   = wr_valid && enable && (wr_addr >= base) && ({1'b0, wr_addr} < limit);
    end
endmodule

// File: rtl/msi_trap_fifo.sv
module msi_trap_fifo
    import msi_trap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  msi_entry_t                   push_entry,
    input  logic                         pop,
    output msi_entry_t                   head,
    output logic                         empty,
    output logic                         full,
    output logic                         drop,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    msi_entry_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        drop    = push && full;
        head    = empty ? '0 : mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[gi] <= '0;
                end else if (push_ok && (wr_ptr == PW'(gi))) begin
                    mem[gi] <= push_entry;
                end
            end
        end
    endgenerate

    // R8: occupancy never exceeds the depth
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R10: simultaneous accepted push and pop keep the count
    p_push_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && pop && !empty) |=> (count == $past(count)));
endmodule

// File: rtl/msi_trap_popseq.sv
module msi_trap_popseq
    import msi_trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic rd_data,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic pop
);
    progress_e state;
    progress_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PR_NONE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!empty) begin
            unique case (state)
                PR_NONE: begin
                    if (rd_data)    state_nx = PR_DATA;
                    else if (rd_lo) state_nx = PR_LO;
                end
                PR_DATA: if (rd_lo)   state_nx = PR_BOTH;
                PR_LO:   if (rd_data) state_nx = PR_BOTH;
                PR_BOTH: if (rd_hi)   state_nx = PR_NONE;
                default: state_nx = PR_NONE;
            endcase
        end
    end

    always_comb begin
        pop = (state == PR_BOTH) && rd_hi && !empty;
    end

    // R6: a retire only comes from the both-read state
    p_pop_after_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state == PR_NONE));
endmodule

// File: rtl/msi_trap.sv
module msi_trap
    import msi_trap_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int REG_AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_wr_valid,
    input  logic [63:0]       in_wr_addr,
    input  logic [31:0]       in_wr_data,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [31:0]   base_lo;
    logic [31:0]   base_hi;
    logic [31:0]   win_size;
    logic          enable;
    logic          ovf;
    logic          hit;
    logic          pop;
    logic          empty;
    logic          full;
    logic          drop;
    logic [CW-1:0] count;
    msi_entry_t    head;
    msi_entry_t    in_entry;
    logic          rd_data;
    logic          rd_lo;
    logic          rd_hi;
    logic          clr_ovf;

    always_comb begin
        in_entry.addr = in_wr_addr;
        in_entry.data = in_wr_data;
        rd_data = reg_rd_en && (reg_addr == REG_AW'(OFS_POP_DATA));
        rd_lo   = reg_rd_en && (reg_addr == REG_AW'(OFS_POP_ADLO));
        rd_hi   = reg_rd_en && (reg_addr == REG_AW'(OFS_POP_ADHI));
        clr_ovf = reg_wr_en && (reg_addr == REG_AW'(OFS_STATUS)) && reg_wdata[1];
    end

    msi_trap_window #(.AW(64), .SW(32)) u_window (
        .enable   (enable),
        .base     ({base_hi, base_lo}),
        .size     (win_size),
        .wr_valid (in_wr_valid),
        .wr_addr  (in_wr_addr),
        .hit      (hit)
    );

    msi_trap_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (hit),
        .push_entry (in_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .full       (full),
        .drop       (drop),
        .count      (count)
    );

    msi_trap_popseq u_popseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .empty   (empty),
        .rd_data (rd_data),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .pop     (pop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo  <= '0;
            base_hi  <= '0;
            win_size <= '0;
            enable   <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            if (reg_wr_en) begin
                if (reg_addr == REG_AW'(OFS_BASE_LO)) base_lo  <= reg_wdata;
                if (reg_addr == REG_AW'(OFS_BASE_HI)) base_hi  <= reg_wdata;
                if (reg_addr == REG_AW'(OFS_SIZE))    win_size <= reg_wdata;
                if (reg_addr == REG_AW'(OFS_ENABLE))  enable   <= reg_wdata[0];
            end
            if (drop) begin
                ovf <= 1'b1;
            end else if (clr_ovf) begin
                ovf <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_BASE_LO))  reg_rdata = base_lo;
        if (reg_addr == REG_AW'(OFS_BASE_HI))  reg_rdata = base_hi;
        if (reg_addr == REG_AW'(OFS_SIZE))     reg_rdata = win_size;
        if (reg_addr == REG_AW'(OFS_ENABLE))   reg_rdata = {31'd0, enable};
        if (reg_addr == REG_AW'(OFS_STATUS))   reg_rdata = {30'd0, ovf, !empty};
        if (reg_addr == REG_AW'(OFS_POP_DATA)) reg_rdata = head.data;
        if (reg_addr == REG_AW'(OFS_POP_ADLO)) reg_rdata = head.addr[31:0];
        if (reg_addr == REG_AW'(OFS_POP_ADHI)) reg_rdata = head.addr[63:32];
        irq_o = !empty;
    end

    // R6: a payload read alone never changes occupancy
    p_data_read_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !hit) |=> $stable(count));

    // R7: popped fields read zero on an empty queue
    p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && (rd_data || rd_lo || rd_hi)) |-> (reg_rdata == 32'd0));

    // R9: overflow flag holds until a clearing write
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    // R5: interrupt drops once the last record retires
    p_irq_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (count == CW'(1)) && !hit) |=> !irq_o);

    // R8: a drop always raises the overflow flag
    p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && hit) |=> ovf);
endmodule

// File: tb/msi_trap_bench.sv
module msi_trap_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WATCHDOG   = 100000;
    localparam logic [63:0] BASE = 64'h0000_0012_3400_0000;
    localparam logic [31:0] SIZE = 32'd4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_wr_valid = 1'b0;
    logic [63:0] in_wr_addr = '0;
    logic [31:0] in_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    logic [31:0] q_data[$];
    logic [63:0] q_addr[$];
    bit m_seen_d = 0;
    bit m_seen_l = 0;
    bit m_ovf    = 0;
    bit m_en     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_trap u_msi_trap (
        .clk(clk), .rst_n(rst_n),
        .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic bit in_window(input logic [63:0] a);
        return m_en && (a >= BASE) && ({1'b0, a} < ({1'b0, BASE} + {33'd0, SIZE}));
    endfunction

    function automatic logic [31:0] exp_status();
        return {30'd0, m_ovf, (q_data.size() != 0)};
    endfunction

    task automatic model_capture(input logic [63:0] a, input logic [31:0] d, input bit was_full);
        if (in_window(a)) begin
            if (was_full) m_ovf = 1;
            else begin
                q_data.push_back(d);
                q_addr.push_back(a);
            end
        end
    endtask

    // returns expected read value and updates the model's read progress
    task automatic model_read(input logic [7:0] a, output logic [31:0] exp);
        exp = '0;
        if (a == 8'h18) exp = exp_status();
        else if (q_data.size() != 0) begin
            if (a == 8'h20) begin exp = q_data[0]; m_seen_d = 1; end
            if (a == 8'h24) begin exp = q_addr[0][31:0]; m_seen_l = 1; end
            if (a == 8'h28) begin
                exp = q_addr[0][63:32];
                if (m_seen_d && m_seen_l) begin
                    void'(q_data.pop_front());
                    void'(q_addr.pop_front());
                    m_seen_d = 0;
                    m_seen_l = 0;
                end
            end
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 0;
        if (a == 8'h14) m_en = d[0];
        if (a == 8'h18 && d[1]) m_ovf = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_en = 1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd_en = 0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        logic [31:0] v;
        logic [31:0] e;
        reg_read(a, v);
        model_read(a, e);
        check(req, {32'd0, v}, {32'd0, e});
    endtask

    task automatic inbound(input logic [63:0] a, input logic [31:0] d);
        bit was_full;
        was_full = (q_data.size() == DEPTH);
        @(negedge clk);
        in_wr_valid = 1; in_wr_addr = a; in_wr_data = d;
        @(posedge clk); #1;
        in_wr_valid = 0;
        model_capture(a, d, was_full);
    endtask

    // inbound write and register read in the same cycle
    task automatic inbound_and_read(input logic [63:0] a, input logic [31:0] d,
                                    input logic [7:0] ra, input string req);
        bit was_full;
        logic [31:0] v;
        logic [31:0] e;
        was_full = (q_data.size() == DEPTH);
        @(negedge clk);
        in_wr_valid = 1; in_wr_addr = a; in_wr_data = d;
        reg_rd_en = 1; reg_addr = ra;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        in_wr_valid = 0; reg_rd_en = 0;
        model_read(ra, e);
        model_capture(a, d, was_full);
        check(req, {32'd0, v}, {32'd0, e});
    endtask

    task automatic check_irq(input string req);
        #1 check(req, {63'd0, irq_o}, {63'd0, (q_data.size() != 0)});
    endtask

    task automatic drain(input string req);
        while (q_data.size() != 0) begin
            read_check(req, 8'h20);
            read_check(req, 8'h24);
            read_check(req, 8'h28);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired got=%0d exp=<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset values
        read_check("R1 base lo", 8'h04);
        read_check("R1 base hi", 8'h08);
        read_check("R1 size", 8'h0C);
        read_check("R1 enable", 8'h14);
        read_check("R1 status", 8'h18);
        check_irq("R1 irq");

        // R2 register read-back
        reg_write(8'h04, BASE[31:0]);
        reg_write(8'h08, BASE[63:32]);
        reg_write(8'h0C, SIZE);
        reg_read(8'h04, v); check("R2 base lo", {32'd0, v}, {32'd0, BASE[31:0]});
        reg_read(8'h08, v); check("R2 base hi", {32'd0, v}, {32'd0, BASE[63:32]});
        reg_read(8'h0C, v); check("R2 size", {32'd0, v}, {32'd0, SIZE});

        // R3 disabled: in-window write ignored
        inbound(BASE + 64'd8, 32'd2);
        read_check("R3 disabled ignored", 8'h18);
        check_irq("R3 disabled irq");

        reg_write(8'h14, 32'hFFFF_FFFF);
        reg_read(8'h14, v); check("R2 enable bit0 only", {32'd0, v}, 64'd1);

        // R3 window edges
        inbound(BASE - 64'd4, 32'hAAAA);
        inbound(BASE + {32'd0, SIZE}, 32'hBBBB);
        read_check("R3 out of window ignored", 8'h18);
        inbound(BASE + {32'd0, SIZE} - 64'd4, 32'h0000_03FF);
        read_check("R3 last word captured", 8'h18);
        check_irq("R5 irq high");
        drain("R3 last word fields");
        check_irq("R5 irq low after drain");

        // R4 vector order and fields
        for (int n = 0; n < 4; n++) inbound(BASE + 64'(4 * n), 32'(n));
        read_check("R5 status pending", 8'h18);
        drain("R4 vector order");

        // R6 partial reads do not pop
        inbound(BASE + 64'd20, 32'd5);
        inbound(BASE + 64'd24, 32'd6);
        read_check("R6 data read", 8'h20);
        read_check("R6 data-only keeps pending", 8'h18);
        read_check("R6 early hi read no pop", 8'h28);
        read_check("R6 head still first", 8'h20);
        read_check("R6 lo read", 8'h24);
        read_check("R6 hi retires", 8'h28);
        read_check("R6 next head", 8'h20);
        // reverse order lo then data
        drain("R6 drain");
        inbound(BASE + 64'd28, 32'd7);
        read_check("R6 lo first", 8'h24);
        read_check("R6 data second", 8'h20);
        read_check("R6 hi pops", 8'h28);
        read_check("R6 empty after pop", 8'h18);

        // R7 empty reads return zero, no side effect
        read_check("R7 empty data", 8'h20);
        read_check("R7 empty lo", 8'h24);
        read_check("R7 empty hi", 8'h28);
        inbound(BASE + 64'd12, 32'd3);
        read_check("R7 hi not retired after empty reads", 8'h28);
        read_check("R7 status", 8'h18);
        drain("R7 drain");

        // R8 fill, overflow, and full-with-pop drop
        for (int n = 0; n < DEPTH; n++) inbound(BASE + 64'(4 * (n % 16)), 32'(n + 100));
        read_check("R8 full no ovf", 8'h18);
        read_check("R8 prep data", 8'h20);
        read_check("R8 prep lo", 8'h24);
        inbound_and_read(BASE, 32'hDEAD, 8'h28, "R8 full drop with pop");
        read_check("R8 ovf set", 8'h18);
        inbound(BASE + 64'd4, 32'hBEEF);
        // R9 sticky overflow
        reg_write(8'h18, 32'h1);
        read_check("R9 write bit1=0 keeps ovf", 8'h18);
        reg_write(8'h18, 32'h2);
        read_check("R9 write bit1=1 clears ovf", 8'h18);
        drain("R8 order after overflow");

        // R10 capture and pop in the same cycle
        inbound(BASE + 64'd36, 32'd9);
        read_check("R10 data", 8'h20);
        read_check("R10 lo", 8'h24);
        inbound_and_read(BASE + 64'd40, 32'd10, 8'h28, "R10 hi with capture");
        read_check("R10 one pending", 8'h18);
        read_check("R10 new head data", 8'h20);
        read_check("R10 new head lo", 8'h24);
        read_check("R10 new head hi", 8'h28);
        read_check("R10 empty", 8'h18);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 9;
            if (r <= 2) begin
                int n;
                n = $urandom % 16;
                inbound(BASE + 64'(4 * n), 32'(n));
            end else if (r == 3) begin
                a = ($urandom % 2) ? BASE + {32'd0, SIZE} + 64'(4 * ($urandom % 64))
                                   : BASE - 64'(4 * (1 + $urandom % 64));
                inbound(a, $urandom);
            end else if (r == 4) read_check("R4 random data", 8'h20);
            else if (r == 5) read_check("R4 random lo", 8'h24);
            else if (r == 6) read_check("R6 random hi", 8'h28);
            else if (r == 7) read_check("R5 random status", 8'h18);
            else reg_write(8'h18, 32'h2);
            check_irq("R5 random irq");
        end
        drain("R4 final drain");
        check_irq("R5 final irq");

        finish_run();
    end
endmodule